// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the address for a four-beat memory burst. When either of two address strobes is seen on a rising clock edge, it captures the full address. The upper bits are held unchanged for the whole burst. The two low bits become the starting beat.

Each later edge with the advance input high moves the burst one beat on. Edges without advance leave the address where it is. A static order input picks how the low bits move:

- Linear: a wrapping up-count.
- Interleaved: the start value XOR the beat index.

A wrap flag marks the last of the four beats. If advance stays high after that beat, the burst starts over from its first beat.

The sequencer sits between a bus front end and a memory array. The array takes `burst_addr` as its word address each cycle.

Top module: `burst_seq_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `burst_addr` is all zeros and `last_beat` is 0.
- R2: A rising edge with `strb_host` or `strb_ctl` high (either one or both) captures `addr_in`. From the following cycle `burst_addr` equals that captured address, and the beat index is 0.
- R3: The bits of `burst_addr` above the low two bits equal the upper bits of the last captured address. Advancing never changes them.
- R4: On an edge with no strobe and `adv` high, the beat index goes up by one, modulo 4. On an edge with no strobe and `adv` low, `burst_addr` and `last_beat` stay as they were.
- R5: With `order_sel` = 0 (linear), the low two bits show (start + beat) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R6: With `order_sel` = 1 (interleaved), the low two bits show start XOR beat. For example, a start of 1 gives 1, 0, 3, 2.
- R7: A strobe on an edge where `adv` is also high reloads the address, and the beat index goes to 0. The strobe wins over the advance.
- R8: `last_beat` is 1 exactly while beat index 3 is presented. One more advance returns the low bits to the start value, with `last_beat` back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_host | input | 1 | First address strobe; captures `addr_in` |
| strb_ctl | input | 1 | Second address strobe; captures `addr_in` |
| adv | input | 1 | Step to the next beat |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W (20) | Burst starting address |
| burst_addr | output | ADDR_W (20) | Current beat address |
| last_beat | output | 1 | High while the fourth beat is presented |

## Verification
Two things can be asked of the block on the same edge: a strobe (load) and an advance (step).

The bench raises `adv` together with a strobe, both in the middle of a burst and on the wrapping beat. It then expects the new start address at beat 0, not a stepped address.

A second overlap is the wrap with a continued advance. The bench expects `last_beat` to fall and the low bits to return to the start value on the next edge.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_INTLV  = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] beat,
  output logic             last
);
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             beat_en;

  always_comb begin
    beat_en = load | step;
    beat_d  = beat_q;
    if (load)      beat_d = '0;
    else if (step) beat_d = beat_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat = beat_q;
  assign last = &beat_q;

  // R7: a load forces beat 0 even when a step is also requested
  p_load_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat == '0));
  // R4: a step without a load moves exactly one beat
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> (beat == $past(beat) + CNT_W'(1)));
  // R4: no load and no step means the beat holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2,
  localparam int HI_W  = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [HI_W-1:0]   base_hi,
  output logic [CNT_W-1:0]  start
);
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [CNT_W-1:0] st_q, st_d;

  always_comb begin
    hi_d = addr_in[ADDR_W-1:CNT_W];
    st_d = addr_in[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      st_q <= '0;
    end else if (load) begin
      hi_q <= hi_d;
      st_q <= st_d;
    end
  end

  assign base_hi = hi_q;
  assign start   = st_q;

  // R3: the upper bits change only through a load
  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_hi));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import bseq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  order_e           order,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] beat,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] xor_low;

  always_comb lin_low = start + beat;

  for (genvar g = 0; g < CNT_W; g++) begin : g_xor_bit
    assign xor_low[g] = start[g] ^ beat[g];
  end

  always_comb begin
    case (order)
      ORD_INTLV: low = xor_low;
      default:   low = lin_low;
    endcase
  end

  // R6: the two orders agree at beat 0, and both present the start value
  always_comb begin
    if (beat == '0) a_beat0_r6: assert (low == start);
  end
endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEATS  = 4,
  localparam int CNT_W = $clog2(BEATS),
  localparam int HI_W  = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_host,
  input  logic              strb_ctl,
  input  logic              adv,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] burst_addr,
  output logic              last_beat
);
  logic             load;
  logic [CNT_W-1:0] beat;
  logic [CNT_W-1:0] start;
  logic [CNT_W-1:0] low;
  logic [HI_W-1:0]  base_hi;
  order_e           order;

  assign load  = strb_host | strb_ctl;
  assign order = order_e'(order_sel);

  burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(adv),
    .beat(beat), .last(last_beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
    .base_hi(base_hi), .start(start)
  );

  burst_order_map #(.CNT_W(CNT_W)) u_map (
    .order(order), .start(start), .beat(beat), .low(low)
  );

  assign burst_addr = {base_hi, low};

  // R2: a strobe makes the captured address appear on the next cycle
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (burst_addr == $past(addr_in)));
  // R8: advancing from the last beat clears the wrap flag
  p_wrap_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && adv && !load) |=> !last_beat);
  // R8: with the order held, advancing from the last beat returns to the start value
  p_wrap_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && adv && !load && $stable(order_sel))
      |=> (burst_addr[CNT_W-1:0] == start));
endmodule

// File: tb/sim_burst_seq_top.sv
module sim_burst_seq_top;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strb_host;
  logic          strb_ctl;
  logic          adv;
  logic          order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] burst_addr;
  logic          last_beat;

  int n_chk  = 0;
  int n_fail = 0;

  logic [AW-3:0] m_hi;
  logic [1:0]    m_st;
  logic [1:0]    m_beat;

  always #10 clk = ~clk;

  burst_seq_top u0 (
    .clk(clk), .rst_n(rst_n), .strb_host(strb_host), .strb_ctl(strb_ctl),
    .adv(adv), .order_sel(order_sel), .addr_in(addr_in),
    .burst_addr(burst_addr), .last_beat(last_beat)
  );

  task automatic check(input string req);
    logic [1:0]    lo;
    logic [AW-1:0] exp_a;
    logic          exp_w;
    lo    = order_sel ? (m_st ^ m_beat) : (m_st + m_beat);
    exp_a = {m_hi, lo};
    exp_w = (m_beat == 2'd3);
    n_chk++;
    if (burst_addr !== exp_a || last_beat !== exp_w) begin
      n_fail++;
      $display("FAIL %s: addr=%h wrap=%b expected addr=%h wrap=%b",
               req, burst_addr, last_beat, exp_a, exp_w);
    end
  endtask

  task automatic cyc(input logic sa, input logic sb, input logic av,
                     input logic [AW-1:0] a, input string req);
    @(negedge clk);
    strb_host = sa;
    strb_ctl  = sb;
    adv       = av;
    addr_in   = a;
    if (sa || sb) begin
      m_hi   = a[AW-1:2];
      m_st   = a[1:0];
      m_beat = 2'd0;
    end else if (av) begin
      m_beat = m_beat + 2'd1;
    end
    @(posedge clk);
    #5;
    check(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; strb_host = 0; strb_ctl = 0; adv = 0;
    order_sel = 0; addr_in = '0;
    m_hi = '0; m_st = '0; m_beat = '0;
    #25;
    check("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check("R1 after release");
  endtask

  task automatic t_linear;
    order_sel = 1'b0;
    cyc(1, 0, 0, 20'hABCD2, "R2 load via host strobe");
    cyc(0, 0, 1, 20'h00000, "R5 linear beat1");
    cyc(0, 0, 1, 20'h11111, "R5 linear beat2 R3 upper held");
    cyc(0, 0, 1, 20'h00000, "R8 linear last beat");
    cyc(0, 0, 1, 20'h00000, "R8 repeat from start");
  endtask

  task automatic t_intlv;
    order_sel = 1'b1;
    cyc(0, 1, 0, 20'h54321, "R2 load via ctl strobe");
    cyc(0, 0, 1, 20'h0, "R6 interleave beat1");
    cyc(0, 0, 1, 20'h0, "R6 interleave beat2");
    cyc(0, 0, 1, 20'h0, "R6 R8 interleave last");
    cyc(0, 0, 1, 20'h0, "R8 interleave repeat");
  endtask

  task automatic t_hold;
    order_sel = 1'b0;
    cyc(1, 1, 0, 20'hF00F3, "R2 both strobes");
    cyc(0, 0, 0, 20'hFFFFF, "R4 hold no advance");
    cyc(0, 0, 0, 20'h00000, "R4 hold again");
    cyc(0, 0, 1, 20'h00000, "R4 step after hold");
  endtask

  task automatic t_priority;
    order_sel = 1'b0;
    cyc(1, 0, 0, 20'h12340, "R2 load");
    cyc(0, 0, 1, 20'h0, "R5 step");
    cyc(1, 0, 1, 20'h9ABC1, "R7 strobe beats advance");
    cyc(0, 0, 1, 20'h0, "R7 step after reload");
    cyc(0, 0, 1, 20'h0, "R5 step");
    cyc(0, 0, 1, 20'h0, "R8 last");
    cyc(0, 1, 1, 20'h7777E, "R7 strobe on wrap beat");
    cyc(0, 0, 0, 20'h0, "R3 upper after reload");
  endtask

  initial begin
    t_reset();
    t_linear();
    t_intlv();
    t_hold();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule